// File: doc/BRIEF.md
# Phased-Access L2 Way Selection Controller

This controller sequences the enables of a phased second-level cache in which the tag arrays are read first and the data arrays afterwards. Stores from a write-through first-level cache come with a status bit that marks a first-level write hit and with a one-hot way number taken from the way decoder. When that bit is set on a write, the way holding the line is already known. The controller then skips the tag phase entirely, keeps every tag way disabled, and drives the data-array way select straight from the decoder.

Every other request goes down the tag path: a first-level write miss, a first-level read miss, or a read that carries a stray hit bit. On this path all tag ways are enabled for one cycle. The per-way compare results from that cycle then pick the data way. If no way matches, the data phase is suppressed and an L2 miss response is returned. A compare result with more than one bit set is also reported as a miss, and it raises an error flag as well. Requests are accepted only while the controller is idle. A busy output holds the requester off until the access completes.

The controller has five states. IDLE waits for a request. TAG_PHASE enables all tag ways. DATA_DIRECT is the data phase for a write hit, with the way taken from the decoder. DATA_TAGGED is the data phase with the way taken from the compare result. MISS_RESP is the suppressed data phase that signals the miss. The transitions are:
- IDLE to DATA_DIRECT on an accepted write hit.
- IDLE to TAG_PHASE on any other accepted request.
- TAG_PHASE to DATA_TAGGED on exactly one match.
- TAG_PHASE to MISS_RESP on no match or on a multi-hot compare.
- DATA_DIRECT, DATA_TAGGED and MISS_RESP back to IDLE unconditionally.

Top module: `pl2_way_ctrl`

## Requirements
- R1: After reset the controller is idle. All outputs are 0: tag_en, data_sel, tag_skipped, busy, done, l2_miss and match_err.
- R2: A request accepted with req_write=1 and req_l1_hit=1 completes in the single cycle after acceptance. In that cycle done=1, tag_skipped=1, tag_en=0, busy=1, and data_sel equals the dec_way value sampled at acceptance. Later changes on dec_way have no effect. In the cycle after that, busy=0 and done=0.
- R3: Any other accepted request enters a tag phase in the cycle after acceptance. In that cycle tag_en has every bit set (one enable per way), busy=1, done=0 and data_sel=0.
- R4: If tag_match has exactly one bit set during the tag phase, the next cycle is the data phase. In it done=1, l2_miss=0, tag_en=0, tag_skipped=0, and data_sel equals that one-hot tag_match value.
- R5: If tag_match is all zero during the tag phase, the next cycle has done=1, l2_miss=1, data_sel=0 and match_err=0. No data way is selected.
- R6: If tag_match has two or more bits set during the tag phase, the next cycle has done=1, l2_miss=1, match_err=1 and data_sel=0.
- R7: While busy=1, req_valid is ignored. After any response cycle (done=1), the controller returns to idle, with busy=0 and done=0, even if a request was held during the access.
- R8: A request with req_write=0 always takes the tag path, even when req_l1_hit=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present; taken only while idle |
| req_write | input | 1 | 1 = write request, 0 = read request |
| req_l1_hit | input | 1 | First-level write-hit status bit |
| dec_way | input | NW | One-hot way number from the way decoder |
| tag_match | input | NW | Per-way tag compare result, valid during the tag phase |
| tag_en | output | NW | Tag-array way enables |
| data_sel | output | NW | Data-array way select, one-hot or zero |
| tag_skipped | output | 1 | The data phase in progress bypassed the tag arrays |
| busy | output | 1 | Controller not idle; requests are held off |
| done | output | 1 | Response cycle of an access |
| l2_miss | output | 1 | Response is an L2 miss; the data phase is suppressed |
| match_err | output | 1 | The tag compare result was multi-hot |

## Verification
Every output comes from registered state, so each result falls a whole number of cycles after the edge that samples its stimulus. A write hit responds in the first cycle after acceptance. The tag phase also appears in that first cycle. A tagged data phase or a miss appears in the second cycle, and idle returns in the cycle after the response. The bench drives inputs on the falling edge and checks outputs at the following falling edge, one per cycle. This fixes each comparison to the exact cycle the requirement names. Changing dec_way or holding req_valid after acceptance shows that the late values do not reach those sampled cycles.

// File: rtl/pl2_pkg.sv
package pl2_pkg;

    typedef enum logic [2:0] {
        ST_IDLE        = 3'd0,
        ST_TAG_PHASE   = 3'd1,
        ST_DATA_DIRECT = 3'd2,
        ST_DATA_TAGGED = 3'd3,
        ST_MISS_RESP   = 3'd4
    } pl2_state_e;

    typedef enum logic [1:0] {
        MC_NONE   = 2'd0,
        MC_SINGLE = 2'd1,
        MC_MULTI  = 2'd2
    } pl2_match_class_e;

endpackage

// File: rtl/pl2_match_classify.sv
module pl2_match_classify #(
    parameter int NW = 4
) (
    input  logic [NW-1:0]                 match_vec,
    output pl2_pkg::pl2_match_class_e     match_class
);
    localparam int CW = $clog2(NW + 1);

    logic [CW-1:0] ones;

    always_comb begin
        ones = '0;
        for (int i = 0; i < NW; i++) begin
            ones = ones + CW'(match_vec[i]);
        end
    end

    always_comb begin
        if (ones == '0) begin
            match_class = pl2_pkg::MC_NONE;
        end else if (ones == CW'(1)) begin
            match_class = pl2_pkg::MC_SINGLE;
        end else begin
            match_class = pl2_pkg::MC_MULTI;
        end
    end
endmodule

// File: rtl/pl2_tag_enable.sv
module pl2_tag_enable #(
    parameter int NW = 4
) (
    input  logic          tag_phase,
    input  logic          hit_bypass,
    output logic [NW-1:0] tag_en
);
    for (genvar g = 0; g < NW; g++) begin : g_way
        assign tag_en[g] = hit_bypass ? 1'b0 : tag_phase;
    end
endmodule

// File: rtl/pl2_way_source.sv
module pl2_way_source #(
    parameter int NW = 4
) (
    input  logic          from_compare,
    input  logic [NW-1:0] dec_way,
    input  logic [NW-1:0] tag_match,
    output logic [NW-1:0] way_next
);
    for (genvar g = 0; g < NW; g++) begin : g_way
        assign way_next[g] = from_compare ? tag_match[g] : dec_way[g];
    end
endmodule

// File: rtl/pl2_way_ctrl.sv
module pl2_way_ctrl #(
    parameter int NW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic          req_l1_hit,
    input  logic [NW-1:0] dec_way,
    input  logic [NW-1:0] tag_match,
    output logic [NW-1:0] tag_en,
    output logic [NW-1:0] data_sel,
    output logic          tag_skipped,
    output logic          busy,
    output logic          done,
    output logic          l2_miss,
    output logic          match_err
);
    import pl2_pkg::*;

    pl2_state_e       state_q;
    pl2_state_e       state_d;
    pl2_match_class_e mclass;
    logic [NW-1:0]    way_q;
    logic [NW-1:0]    way_next;
    logic             err_q;
    logic             accept;
    logic             direct_req;
    logic             in_tag;
    logic             in_direct;
    logic             load_way;

    assign accept     = req_valid && (state_q == ST_IDLE);
    assign direct_req = req_write && req_l1_hit;
    assign in_tag     = (state_q == ST_TAG_PHASE);
    assign in_direct  = (state_q == ST_DATA_DIRECT);

    pl2_match_classify #(.NW(NW)) u_cls (
        .match_vec   (tag_match),
        .match_class (mclass)
    );

    pl2_way_source #(.NW(NW)) u_src (
        .from_compare (in_tag),
        .dec_way      (dec_way),
        .tag_match    (tag_match),
        .way_next     (way_next)
    );

    pl2_tag_enable #(.NW(NW)) u_ten (
        .tag_phase  (in_tag),
        .hit_bypass (in_direct),
        .tag_en     (tag_en)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    state_d = direct_req ? ST_DATA_DIRECT : ST_TAG_PHASE;
                end
            end
            ST_TAG_PHASE: begin
                state_d = (mclass == MC_SINGLE) ? ST_DATA_TAGGED : ST_MISS_RESP;
            end
            ST_DATA_DIRECT: state_d = ST_IDLE;
            ST_DATA_TAGGED: state_d = ST_IDLE;
            ST_MISS_RESP:   state_d = ST_IDLE;
            default:        state_d = ST_IDLE;
        endcase
    end

    assign load_way = (accept && direct_req) || (in_tag && (mclass == MC_SINGLE));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            way_q   <= '0;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (load_way) begin
                way_q <= way_next;
            end
            err_q <= in_tag && (mclass == MC_MULTI);
        end
    end

    always_comb begin
        data_sel    = '0;
        tag_skipped = 1'b0;
        busy        = 1'b1;
        done        = 1'b0;
        l2_miss     = 1'b0;
        match_err   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                busy = 1'b0;
            end
            ST_TAG_PHASE: begin
                busy = 1'b1;
            end
            ST_DATA_DIRECT: begin
                data_sel    = way_q;
                tag_skipped = 1'b1;
                done        = 1'b1;
            end
            ST_DATA_TAGGED: begin
                data_sel = way_q;
                done     = 1'b1;
            end
            ST_MISS_RESP: begin
                done      = 1'b1;
                l2_miss   = 1'b1;
                match_err = err_q;
            end
            default: begin
                busy = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/pl2_way_ctrl_chk.sv
module pl2_way_ctrl_chk #(
    parameter int NW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic          req_write,
    input logic          req_l1_hit,
    input logic [NW-1:0] dec_way,
    input logic [NW-1:0] tag_match,
    input logic [NW-1:0] tag_en,
    input logic [NW-1:0] data_sel,
    input logic          tag_skipped,
    input logic          busy,
    input logic          done,
    input logic          l2_miss,
    input logic          match_err
);
    a_r2_direct_response: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && req_valid && req_write && req_l1_hit)
        |=> (done && tag_skipped && (tag_en == '0) && (data_sel == $past(dec_way))));

    a_r2_skip_no_tag: assert property (@(posedge clk) disable iff (!rst_n)
        tag_skipped |-> (tag_en == '0));

    a_r3_tag_phase_all_ways: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && req_valid && !(req_write && req_l1_hit))
        |=> ((tag_en == '1) && busy && !done && (data_sel == '0)));

    a_r4_single_match_select: assert property (@(posedge clk) disable iff (!rst_n)
        ((tag_en == '1) && ($countones(tag_match) == 1))
        |=> (done && !l2_miss && (data_sel == $past(tag_match))));

    a_r5_miss_no_select: assert property (@(posedge clk) disable iff (!rst_n)
        l2_miss |-> (done && (data_sel == '0) && (tag_en == '0)));

    a_r6_multi_flagged: assert property (@(posedge clk) disable iff (!rst_n)
        ((tag_en == '1) && ($countones(tag_match) > 1))
        |=> (match_err && l2_miss));

    a_r6_err_implies_miss: assert property (@(posedge clk) disable iff (!rst_n)
        match_err |-> l2_miss);

    a_r7_back_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    a_r4_sel_onehot0: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(data_sel));
endmodule

bind pl2_way_ctrl pl2_way_ctrl_chk #(.NW(NW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_write   (req_write),
    .req_l1_hit  (req_l1_hit),
    .dec_way     (dec_way),
    .tag_match   (tag_match),
    .tag_en      (tag_en),
    .data_sel    (data_sel),
    .tag_skipped (tag_skipped),
    .busy        (busy),
    .done        (done),
    .l2_miss     (l2_miss),
    .match_err   (match_err)
);

// File: tb/sim_pl2_way_ctrl.sv
module sim_pl2_way_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int NW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic          req_l1_hit = 1'b0;
    logic [NW-1:0] dec_way = '0;
    logic [NW-1:0] tag_match = '0;
    logic [NW-1:0] tag_en;
    logic [NW-1:0] data_sel;
    logic          tag_skipped;
    logic          busy;
    logic          done;
    logic          l2_miss;
    logic          match_err;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pl2_way_ctrl #(.NW(NW)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_l1_hit(req_l1_hit), .dec_way(dec_way), .tag_match(tag_match),
        .tag_en(tag_en), .data_sel(data_sel), .tag_skipped(tag_skipped),
        .busy(busy), .done(done), .l2_miss(l2_miss), .match_err(match_err)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1 tag_en", 32'(tag_en), 0);
        chk("R1 data_sel", 32'(data_sel), 0);
        chk("R1 flags", {26'd0, tag_skipped, busy, done, l2_miss, match_err, 1'b0}, 0);
    endtask

    task automatic t_write_hit(input logic [NW-1:0] way);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_l1_hit = 1'b1; dec_way = way;
        @(negedge clk);
        req_valid = 1'b0; dec_way = ~way;
        chk("R2 done", 32'(done), 1);
        chk("R2 tag_skipped", 32'(tag_skipped), 1);
        chk("R2 tag_en", 32'(tag_en), 0);
        chk("R2 busy", 32'(busy), 1);
        chk("R2 data_sel", 32'(data_sel), 32'(way));
        @(negedge clk);
        chk("R2 idle after", {30'd0, busy, done}, 0);
    endtask

    task automatic t_tag_path(input string tag, input logic wr, input logic hitbit,
                              input logic [NW-1:0] match, input logic [NW-1:0] exp_sel,
                              input logic exp_miss, input logic exp_err);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_l1_hit = hitbit; dec_way = 4'b0010;
        @(negedge clk);
        req_valid = 1'b0; tag_match = match;
        chk({tag, " R3 tag_en"}, 32'(tag_en), 32'({NW{1'b1}}));
        chk({tag, " R3 busy/done"}, {30'd0, busy, done}, 32'b10);
        chk({tag, " R3 data_sel"}, 32'(data_sel), 0);
        @(negedge clk);
        tag_match = '0;
        chk({tag, " done"}, 32'(done), 1);
        chk({tag, " data_sel"}, 32'(data_sel), 32'(exp_sel));
        chk({tag, " l2_miss"}, 32'(l2_miss), 32'(exp_miss));
        chk({tag, " match_err"}, 32'(match_err), 32'(exp_err));
        chk({tag, " tag_en/skip"}, {27'd0, tag_skipped, tag_en}, 0);
        @(negedge clk);
        chk({tag, " idle"}, {30'd0, busy, done}, 0);
    endtask

    task automatic t_busy_ignore();
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_l1_hit = 1'b0;
        @(negedge clk);
        req_write = 1'b1; req_l1_hit = 1'b1; dec_way = 4'b1000; tag_match = 4'b0001;
        chk("R7 in tag phase", 32'(tag_en), 32'({NW{1'b1}}));
        @(negedge clk);
        tag_match = '0;
        chk("R7 response", 32'(data_sel), 32'(4'b0001));
        chk("R7 no skip", 32'(tag_skipped), 0);
        req_valid = 1'b0;
        @(negedge clk);
        chk("R7 idle", {29'd0, busy, done, tag_skipped}, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_reset();
        t_write_hit(4'b0100);
        t_write_hit(4'b0001);
        t_tag_path("R4 wmiss", 1'b1, 1'b0, 4'b1000, 4'b1000, 1'b0, 1'b0);
        t_tag_path("R4 rmiss", 1'b0, 1'b0, 4'b0010, 4'b0010, 1'b0, 1'b0);
        t_tag_path("R5 nomatch", 1'b1, 1'b0, 4'b0000, 4'b0000, 1'b1, 1'b0);
        t_tag_path("R6 multi", 1'b0, 1'b0, 4'b0110, 4'b0000, 1'b1, 1'b1);
        t_tag_path("R8 read hitbit", 1'b0, 1'b1, 4'b0100, 4'b0100, 1'b0, 1'b0);
        t_busy_ignore();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule